// File: doc/BRIEF.md
# Line-Replicating Raster Scan-Out Controller

This block drives a monitor from a small byte-per-pixel picture held in an external synchronous memory. It counts dot and line positions on a pixel-clock enable and produces an active-low horizontal sync, an active-high vertical sync and a colour byte. Each scan line starts with the sync pulse, then the back porch, then the visible window, then the front porch. The default raster is 1024 dots by 625 lines, with a visible area of 800 by 600.

The stored picture is coarser than the raster. Each stored pixel covers `PIX_DIV` dots across the line. Each stored row is shown on `ROW_REPEAT` consecutive scan lines before the block moves to the next row. Rows are laid out in memory with a stride equal to the stored width plus `PAD_BYTES` pad bytes. The pad bytes are meant to hold zero, so that a line that reads into them ends dark.

A frame-valid flag controls reading. It arms when the vertical back porch ends. It drops after the last repeat of the last stored row. At that moment the block pulses `frame_done` for one clock and reloads its row pointer from `fb_base`. Software uses that pulse to wait until a refresh has finished before it changes the picture.

Top module: `rowrep_scanout`

## Requirements
- R1: `hsync_n` is low for dots 0 to `H_SYNC`-1 of every line and high for all other dots. A line is `H_SYNC`+`H_BACK`+`H_ACTIVE`+`H_FRONT` dots long.
- R2: `vsync` is high on lines 0 to `V_SYNC`-1 of every frame and low on all other lines. A frame is `V_SYNC`+`V_BACK`+`V_ACTIVE`+`V_FRONT` lines long.
- R3: The frame-valid flag sets at the first line after the vertical back porch and clears at the end of the last repeated line. `rd_en` is high exactly for the dots that are both in the visible window and inside a valid frame. It is low on the dot where `frame_done` pulses.
- R4: For a visible dot at horizontal offset x into the window, the read address is the current row base plus x/`PIX_DIV` (integer division). Reads within a line therefore stop at ceil(`H_ACTIVE`/`PIX_DIV`) bytes, which is never more than the padded stride.
- R5: The row base stays the same for `ROW_REPEAT` consecutive visible lines. It then advances by `H_ACTIVE`/`PIX_DIV`+`PAD_BYTES`.
- R6: `pix_out` is the memory byte read for a dot, or zero if that dot was not read. It appears two clocks after the pixel-enabled clock that issued the address, on the same clock as that dot's sync levels.
- R7: `frame_done` is high for exactly one clock. It comes from the enabled clock of the final dot of the last repeated line of the last stored row.
- R8: The first frame after reset reads from base address 0. Every later frame reads from the value of `fb_base` sampled at the preceding `frame_done`.
- R9: While `pix_ce` is low, the raster position, `rd_addr` and `rd_en` hold their values.
- R10: A synchronous active-high reset leaves `hsync_n`=1, `vsync`=0, `pix_out`=0, `rd_en`=0 and `frame_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Dot-rate clock enable |
| fb_base | input | ADDR_W | Frame start address, loaded at each frame end |
| rd_addr | output | ADDR_W | Frame buffer read address |
| rd_en | output | 1 | High when `rd_addr` carries a wanted read |
| rd_data | input | PIX_W | Read data, one clock after the address |
| pix_out | output | PIX_W | Colour byte, zero when blanked |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| frame_done | output | 1 | One-clock pulse when the frame-valid flag clears |

## Verification
The assertions assume two things about the environment. The memory returns data for an address exactly one clock after that address appears. `pix_ce` may drop for any number of clocks, but `rst` is the only other control input.

The bench drives a memory model whose byte is an arithmetic function of the address, so every colour check also confirms which address was read. It runs two full frames with `pix_ce` held high. It then runs frames with a regular two-out-of-three enable pattern and one long gap in the enable. It changes `fb_base` between frame ends, so it stays inside the assumed behaviour while still covering both base-reload cases.

// File: rtl/rowrep_pkg.sv
package rowrep_pkg;

  // Per-dot tags carried down the output pipeline alongside the read.
  typedef struct packed {
    logic vis;
    logic hs_n;
    logic vs;
  } scan_tag_t;

  localparam scan_tag_t TAG_IDLE = '{vis: 1'b0, hs_n: 1'b1, vs: 1'b0};

endpackage

// File: rtl/rr_raster.sv
module rr_raster #(
  parameter int H_ACTIVE = 800,
  parameter int H_FRONT  = 24,
  parameter int H_SYNC   = 72,
  parameter int H_BACK   = 128,
  parameter int V_ACTIVE = 600,
  parameter int V_FRONT  = 1,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic in_hsync,
  output logic in_vsync,
  output logic h_active,
  output logic line_end,
  output logic arm_frame
);

  localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
  localparam int V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;
  localparam int H_START = H_SYNC + H_BACK;
  localparam int V_START = V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  assign line_end  = (hcnt == HW'(H_TOTAL - 1));
  assign in_hsync  = (hcnt < HW'(H_SYNC));
  assign in_vsync  = (vcnt < VW'(V_SYNC));
  assign h_active  = (hcnt >= HW'(H_START)) && (hcnt < HW'(H_START + H_ACTIVE));
  assign arm_frame = line_end && (vcnt == VW'(V_START - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (ce) begin
      if (line_end) begin
        hcnt <= '0;
        vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rr_rowseq.sv
module rr_rowseq #(
  parameter int ROWS   = 150,
  parameter int REPEAT = 4,
  parameter int STRIDE = 269,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              line_end,
  input  logic              arm_frame,
  input  logic [ADDR_W-1:0] base_in,
  output logic              frame_valid,
  output logic [ADDR_W-1:0] row_base,
  output logic              frame_done
);

  localparam int RW = $clog2(ROWS + 1);
  localparam int PW = $clog2(REPEAT + 1);

  logic [RW-1:0] row;
  logic [PW-1:0] rep;
  logic          last_rep;
  logic          last_row;
  logic          step;

  assign step     = ce && line_end;
  assign last_rep = (rep == PW'(REPEAT - 1));
  assign last_row = (row == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      row         <= '0;
      rep         <= '0;
      row_base    <= '0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= step && frame_valid && last_rep && last_row;
      if (step) begin
        if (frame_valid) begin
          if (last_rep) begin
            rep <= '0;
            if (last_row) begin
              row         <= '0;
              frame_valid <= 1'b0;
              row_base    <= base_in;
            end else begin
              row      <= row + 1'b1;
              row_base <= row_base + ADDR_W'(STRIDE);
            end
          end else begin
            rep <= rep + 1'b1;
          end
        end else if (arm_frame) begin
          frame_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rr_colfetch.sv
module rr_colfetch #(
  parameter int PIX_DIV = 3,
  parameter int STRIDE  = 269,
  parameter int CW      = $clog2(STRIDE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          h_active,
  input  logic          line_end,
  output logic [CW-1:0] col
);

  generate
    if (PIX_DIV == 1) begin : g_nodiv
      always_ff @(posedge clk) begin
        if (rst || (ce && line_end)) col <= '0;
        else if (ce && h_active)     col <= col + 1'b1;
      end
    end else begin : g_div
      localparam int DW = $clog2(PIX_DIV);
      logic [DW-1:0] sub;
      always_ff @(posedge clk) begin
        if (rst || (ce && line_end)) begin
          sub <= '0;
          col <= '0;
        end else if (ce && h_active) begin
          if (sub == DW'(PIX_DIV - 1)) begin
            sub <= '0;
            col <= col + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rowrep_scanout.sv
module rowrep_scanout #(
  parameter int H_ACTIVE   = 800,
  parameter int H_FRONT    = 24,
  parameter int H_SYNC     = 72,
  parameter int H_BACK     = 128,
  parameter int V_ACTIVE   = 600,
  parameter int V_FRONT    = 1,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 22,
  parameter int ROW_REPEAT = 4,
  parameter int PIX_DIV    = 3,
  parameter int PAD_BYTES  = 3,
  parameter int ADDR_W     = 18,
  parameter int PIX_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_ce,
  input  logic [ADDR_W-1:0] fb_base,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hsync_n,
  output logic              vsync,
  output logic              frame_done
);

  import rowrep_pkg::*;

  localparam int ROWS   = V_ACTIVE / ROW_REPEAT;
  localparam int COLS   = H_ACTIVE / PIX_DIV;
  localparam int STRIDE = COLS + PAD_BYTES;
  localparam int CW     = $clog2(STRIDE);

  logic              in_hsync, in_vsync, h_active, line_end, arm_frame;
  logic              frame_valid;
  logic [ADDR_W-1:0] row_base;
  logic [CW-1:0]     col;
  logic              vis_now;
  scan_tag_t         tag_s1, tag_s2;

  rr_raster #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_raster (
    .clk(clk), .rst(rst), .ce(pix_ce),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .h_active(h_active),
    .line_end(line_end), .arm_frame(arm_frame)
  );

  rr_rowseq #(
    .ROWS(ROWS), .REPEAT(ROW_REPEAT), .STRIDE(STRIDE), .ADDR_W(ADDR_W)
  ) u_rowseq (
    .clk(clk), .rst(rst), .ce(pix_ce), .line_end(line_end),
    .arm_frame(arm_frame), .base_in(fb_base), .frame_valid(frame_valid),
    .row_base(row_base), .frame_done(frame_done)
  );

  rr_colfetch #(
    .PIX_DIV(PIX_DIV), .STRIDE(STRIDE), .CW(CW)
  ) u_colfetch (
    .clk(clk), .rst(rst), .ce(pix_ce), .h_active(h_active),
    .line_end(line_end), .col(col)
  );

  assign vis_now = h_active && frame_valid;

  // Stage 1: issue address on the dot enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      rd_en   <= 1'b0;
      tag_s1  <= TAG_IDLE;
    end else if (pix_ce) begin
      rd_addr <= row_base + ADDR_W'(col);
      rd_en   <= vis_now;
      tag_s1  <= '{vis: vis_now, hs_n: !in_hsync, vs: in_vsync};
    end
  end

  // Stages 2 and 3: fixed two-clock alignment with the memory latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_s2  <= TAG_IDLE;
      pix_out <= '0;
      hsync_n <= 1'b1;
      vsync   <= 1'b0;
    end else begin
      tag_s2  <= tag_s1;
      pix_out <= tag_s2.vis ? rd_data : '0;
      hsync_n <= tag_s2.hs_n;
      vsync   <= tag_s2.vs;
    end
  end

endmodule

// File: rtl/rowrep_scanout_chk.sv
module rowrep_scanout_chk #(
  parameter int ADDR_W = 18,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_ce,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic [PIX_W-1:0]  pix_out,
  input logic              vsync,
  input logic              frame_done
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_done_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !rd_en);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pix_ce |=> ($stable(rd_addr) && $stable(rd_en)));

  p_vsync_dark_r2: assert property (@(posedge clk) disable iff (rst)
    vsync |-> (pix_out == '0));

  p_colour_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
    (pix_out != '0) |-> $past(rd_en, 2));

endmodule

bind rowrep_scanout rowrep_scanout_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .rd_addr(rd_addr), .rd_en(rd_en),
  .pix_out(pix_out), .vsync(vsync), .frame_done(frame_done)
);

// File: tb/rowrep_scanout_bench.sv
module rowrep_scanout_bench;

  localparam int HA = 14, HF = 2, HS = 3, HB = 2;
  localparam int VA = 8,  VF = 1, VS = 2, VB = 2;
  localparam int REP = 2, DIV = 3, PAD = 3, AW = 16;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int HST = HS + HB;
  localparam int VST = VS + VB;
  localparam int STRIDE = HA / DIV + PAD;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, pix_ce;
  logic [AW-1:0] fb_base, rd_addr;
  logic          rd_en;
  logic [7:0]    rd_data, pix_out;
  logic          hsync_n, vsync, frame_done;

  rowrep_scanout #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .ROW_REPEAT(REP), .PIX_DIV(DIV), .PAD_BYTES(PAD), .ADDR_W(AW), .PIX_W(8)
  ) u_rowrep_scanout (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .fb_base(fb_base),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .pix_out(pix_out),
    .hsync_n(hsync_n), .vsync(vsync), .frame_done(frame_done)
  );

  function automatic logic [7:0] memfn(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  always @(posedge clk) rd_data <= memfn(int'(rd_addr));

  int n_chk = 0, n_err = 0;
  bit chk_on = 0, done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Reference model: expected values per pipeline stage.
  int h_m, v_m, base_m;
  int e1_addr, e2_addr, eo_rgb;
  bit e1_rd, e1_vis, e1_hs, e1_vs, e2_vis, e2_hs, e2_vs, eo_hs, eo_vs, fd_m, ce_prev;

  always @(posedge clk) begin
    ce_prev = pix_ce;
    if (rst) begin
      h_m = 0; v_m = 0; base_m = 0; fd_m = 0;
      e1_rd = 0; e1_vis = 0; e1_hs = 1; e1_vs = 0; e1_addr = 0;
      e2_vis = 0; e2_hs = 1; e2_vs = 0; e2_addr = 0;
      eo_rgb = 0; eo_hs = 1; eo_vs = 0;
    end else begin
      eo_hs = e2_hs; eo_vs = e2_vs;
      eo_rgb = e2_vis ? int'(memfn(e2_addr)) : 0;
      e2_vis = e1_vis; e2_hs = e1_hs; e2_vs = e1_vs; e2_addr = e1_addr;
      fd_m = 0;
      if (pix_ce) begin
        e1_vis = (h_m >= HST && h_m < HST + HA) && (v_m >= VST && v_m < VST + VA);
        e1_rd = e1_vis;
        if (e1_vis) e1_addr = base_m + ((v_m - VST) / REP) * STRIDE + (h_m - HST) / DIV;
        e1_hs = !(h_m < HS);
        e1_vs = (v_m < VS);
        if (h_m == HT - 1 && v_m == VST + VA - 1) begin
          fd_m = 1;
          base_m = int'(fb_base);
        end
        if (h_m == HT - 1) begin
          h_m = 0;
          v_m = (v_m == VT - 1) ? 0 : v_m + 1;
        end else begin
          h_m++;
        end
      end
    end
  end

  logic [AW-1:0] last_addr;
  logic          last_rd;
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(hsync_n == eo_hs, "R1 hsync", int'(hsync_n), int'(eo_hs));
      check(vsync == eo_vs, "R2 vsync", int'(vsync), int'(eo_vs));
      check(rd_en == e1_rd, "R3 read enable", int'(rd_en), int'(e1_rd));
      if (e1_rd) check(int'(rd_addr) == e1_addr, "R4 R5 R8 address", int'(rd_addr), e1_addr);
      check(int'(pix_out) == eo_rgb, "R6 colour", int'(pix_out), eo_rgb);
      check(frame_done == fd_m, "R7 frame_done", int'(frame_done), int'(fd_m));
      if (!ce_prev) begin
        check(rd_addr == last_addr, "R9 stall address", int'(rd_addr), int'(last_addr));
        check(rd_en == last_rd, "R9 stall enable", int'(rd_en), int'(last_rd));
      end
    end
    last_addr = rd_addr;
    last_rd   = rd_en;
  end

  task automatic check_reset_state();
    check(hsync_n == 1'b1, "R10 reset hsync", int'(hsync_n), 1);
    check(vsync == 1'b0, "R10 reset vsync", int'(vsync), 0);
    check(pix_out == 8'd0, "R10 reset colour", int'(pix_out), 0);
    check(rd_en == 1'b0, "R10 reset read", int'(rd_en), 0);
    check(frame_done == 1'b0, "R10 reset done", int'(frame_done), 0);
  endtask

  initial begin
    rst = 1'b1; pix_ce = 1'b0; fb_base = 16'h0100;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0; pix_ce = 1'b1;
    @(posedge clk);
    chk_on = 1;
    // Continuous enable: two frames; base changes after the first frame end.
    for (int i = 0; i < 2 * HT * VT + 60; i++) begin
      @(negedge clk);
      if (i == HT * VT + 40) fb_base = 16'h0200;
    end
    // Mid-run reset.
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // Enable with gaps: regular pattern plus one long stall.
    for (int i = 0; i < 3 * HT * VT * 3 / 2; i++) begin
      if (i >= 500 && i < 530) pix_ce = 1'b0;
      else pix_ce = (i % 3 != 2);
      if (i == 600) fb_base = 16'h0321;
      @(negedge clk);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule